// File: doc/BRIEF.md
# Speculative Branch Path History Buffer

This block keeps an ordered record of recently predicted indirect branches. Each record holds the branch address, the target that was finally resolved for it, and the sequence number of the branch. The front end pushes a record when it predicts an indirect branch. It fills in the resolved target of the youngest record once that target is known. The back end commits records by sequence number as branches retire, and it squashes every record younger than a given sequence number when a misprediction flushes the pipe.

The buffer presents the targets of its newest `PATH_LEN` records, youngest first, for use by an index hash that follows it. It also presents the branch address of the youngest record. Commit does not free a record at once. It moves a committed-head counter forward, so that up to `PATH_LEN` committed records stay visible to the hash. Only when that window is full does a further commit retire the oldest record. Storage is a ring of `DEPTH` slots (a power of two, with `PATH_LEN <= DEPTH`). A push into a full ring drops the oldest record and sets a sticky overflow flag. Sequence numbers are compared as plain unsigned values.

Top module: `path_hist_buf`

## Requirements
- R1: After reset, `occ` is 0, `committed` is 0, `overflow` is 0, and `young_pc` and every lane of `path_tgt` are 0.
- R2: A push appends a record {`ps_pc`, `ps_seq`, target 0} at the young end. `occ` rises by one, `young_pc` shows `ps_pc`, and lane p of `path_tgt` (bits p*AW upward) shows the target of the p-th youngest record, with lane 0 being the youngest.
- R3: A push when `occ` equals `DEPTH` discards the oldest record and stores the new one as youngest. `occ` stays at `DEPTH`, and `overflow` goes to 1 and stays there until reset.
- R4: A target write replaces the target of the youngest record with `tg_addr`. On an empty buffer it has no effect.
- R5: A commit on an empty buffer changes neither `occ` nor `committed`.
- R6: A commit acts only when `committed` < `occ` and the record at committed-head position `committed` (counted from the oldest) has a sequence number <= `cm_seq`. If `committed` < `PATH_LEN`, `committed` rises by one. Otherwise the oldest record is retired (`occ` falls by one) and `committed` is unchanged. A commit handles at most one record.
- R7: A commit whose number is below the sequence number of the head record changes nothing.
- R8: A squash finds the oldest record whose sequence number exceeds `sq_seq`, and removes that record and all younger ones in one cycle. If no such record exists, nothing changes. `committed` is not altered.
- R9: Lanes of `path_tgt` at positions >= `occ` read 0, and `young_pc` reads 0 when the buffer is empty.
- R10: When several operations are requested in one cycle, only one acts, in the order squash, target write, push, commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sq_en | input | 1 | Squash request |
| sq_seq | input | SW | Squash boundary sequence number |
| tg_en | input | 1 | Target write request for the youngest record |
| tg_addr | input | AW | Resolved target address |
| ps_en | input | 1 | Push request |
| ps_pc | input | AW | Branch address of the pushed record |
| ps_seq | input | SW | Sequence number of the pushed record |
| cm_en | input | 1 | Commit request |
| cm_seq | input | SW | Commit sequence number |
| occ | output | CW | Number of records held |
| committed | output | HW | Committed-head position |
| overflow | output | 1 | Sticky flag: a record was dropped by a push into a full buffer |
| young_pc | output | AW | Branch address of the youngest record, 0 when empty |
| path_tgt | output | PATH_LEN*AW | Targets of the newest records, lane 0 youngest |

## Verification
The hardest state to reach from the ports is the retiring branch of commit. It needs `PATH_LEN` successful commits to fill the committed window, and then a younger record whose sequence number the next commit covers. A close second is a stale committed head left beyond `occ` after a squash. The vector table builds both states in order: it fills three records, commits until the window is full, tries one commit too many, pushes a fourth record, and commits it to force a retirement. It then squashes down to empty and checks that later commits are blocked by the stale head. Directed runs fill the ring past `DEPTH` to exercise overflow, and raise several requests in the same cycle to exercise priority.

// File: rtl/phb_pkg.sv
package phb_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_SQUASH = 3'd1,
    OP_TARGET = 3'd2,
    OP_PUSH   = 3'd3,
    OP_COMMIT = 3'd4
  } phb_op_e;

  // one operation per cycle: squash wins, then target write, push, commit
  function automatic phb_op_e pick_op(input logic sq, input logic tg,
                                      input logic ps, input logic cm);
    if (sq) return OP_SQUASH;
    if (tg) return OP_TARGET;
    if (ps) return OP_PUSH;
    if (cm) return OP_COMMIT;
    return OP_NONE;
  endfunction

endpackage

// File: rtl/phb_ring.sv
module phb_ring #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int SW    = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_slot,
  input  logic [AW-1:0] wr_pc,
  input  logic [SW-1:0] wr_seq,
  input  logic          tg_en,
  input  logic [PW-1:0] tg_slot,
  input  logic [AW-1:0] tg_addr,
  output logic [AW-1:0] pc_o  [DEPTH],
  output logic [AW-1:0] tgt_o [DEPTH],
  output logic [SW-1:0] seq_o [DEPTH]
);

  logic [AW-1:0] pc_q  [DEPTH];
  logic [AW-1:0] tgt_q [DEPTH];
  logic [SW-1:0] seq_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q[i]  <= '0;
        tgt_q[i] <= '0;
        seq_q[i] <= '0;
      end else if (wr_en && wr_slot == PW'(i)) begin
        pc_q[i]  <= wr_pc;
        tgt_q[i] <= '0;
        seq_q[i] <= wr_seq;
      end else if (tg_en && tg_slot == PW'(i)) begin
        tgt_q[i] <= tg_addr;
      end
    end
    assign pc_o[i]  = pc_q[i];
    assign tgt_o[i] = tgt_q[i];
    assign seq_o[i] = seq_q[i];
  end

endmodule

// File: rtl/phb_search.sv
module phb_search #(
  parameter int DEPTH = 8,
  parameter int SW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [PW-1:0] rd_ptr,
  input  logic [CW-1:0] cnt,
  input  logic [SW-1:0] key,
  input  logic [SW-1:0] seq_i [DEPTH],
  output logic          hit,
  output logic [CW-1:0] off
);

  function automatic logic [PW-1:0] slot_at(input logic [PW-1:0] base,
                                            input logic [CW-1:0] o);
    logic [CW:0] s;
    s = (CW+1)'(base) + (CW+1)'(o);
    return s[PW-1:0];
  endfunction

  logic [DEPTH-1:0] younger;

  // younger[k]: record at age offset k (0 = oldest) is past the key
  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    assign younger[k] = (CW'(k) < cnt) && (seq_i[slot_at(rd_ptr, CW'(k))] > key);
  end

  always_comb begin
    hit = 1'b0;
    off = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (younger[k]) begin
        hit = 1'b1;
        off = CW'(k);
      end
    end
  end

endmodule

// File: rtl/phb_path_sel.sv
module phb_path_sel #(
  parameter int DEPTH    = 8,
  parameter int PATH_LEN = 3,
  parameter int AW       = 16,
  localparam int PW      = $clog2(DEPTH),
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic [PW-1:0]          rd_ptr,
  input  logic [CW-1:0]          cnt,
  input  logic [AW-1:0]          tgt_i [DEPTH],
  output logic [PATH_LEN*AW-1:0] path_o
);

  function automatic logic [PW-1:0] slot_at(input logic [PW-1:0] base,
                                            input logic [CW-1:0] o);
    logic [CW:0] s;
    s = (CW+1)'(base) + (CW+1)'(o);
    return s[PW-1:0];
  endfunction

  for (genvar p = 0; p < PATH_LEN; p++) begin : g_lane
    logic          live;
    logic [CW-1:0] age;
    assign live = CW'(p) < cnt;
    assign age  = cnt - CW'(1) - CW'(p);
    assign path_o[p*AW +: AW] = live ? tgt_i[slot_at(rd_ptr, age)] : '0;
  end

endmodule

// File: rtl/path_hist_buf.sv
module path_hist_buf #(
  parameter int DEPTH    = 8,
  parameter int PATH_LEN = 3,
  parameter int AW       = 16,
  parameter int SW       = 8,
  localparam int PW      = $clog2(DEPTH),
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int HW      = $clog2(PATH_LEN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sq_en,
  input  logic [SW-1:0]          sq_seq,
  input  logic                   tg_en,
  input  logic [AW-1:0]          tg_addr,
  input  logic                   ps_en,
  input  logic [AW-1:0]          ps_pc,
  input  logic [SW-1:0]          ps_seq,
  input  logic                   cm_en,
  input  logic [SW-1:0]          cm_seq,
  output logic [CW-1:0]          occ,
  output logic [HW-1:0]          committed,
  output logic                   overflow,
  output logic [AW-1:0]          young_pc,
  output logic [PATH_LEN*AW-1:0] path_tgt
);

  import phb_pkg::*;

  function automatic logic [PW-1:0] slot_at(input logic [PW-1:0] base,
                                            input logic [CW-1:0] o);
    logic [CW:0] s;
    s = (CW+1)'(base) + (CW+1)'(o);
    return s[PW-1:0];
  endfunction

  logic [PW-1:0] rd_q;
  logic [CW-1:0] cnt_q;
  logic [HW-1:0] head_q;
  logic          ovf_q;

  logic [AW-1:0] pc_arr  [DEPTH];
  logic [AW-1:0] tgt_arr [DEPTH];
  logic [SW-1:0] seq_arr [DEPTH];

  // named events, observed by the bound checker
  phb_op_e       op;
  logic          do_squash, do_tgt, do_push, do_commit;
  logic          empty, full;
  logic          tgt_fire, push_drop;
  logic          commit_ok, commit_adv, commit_retire;
  logic          sq_hit, squash_cut;
  logic [CW-1:0] sq_off;
  logic [PW-1:0] young_slot, wr_slot, head_slot;

  assign op        = pick_op(sq_en, tg_en, ps_en, cm_en);
  assign do_squash = (op == OP_SQUASH);
  assign do_tgt    = (op == OP_TARGET);
  assign do_push   = (op == OP_PUSH);
  assign do_commit = (op == OP_COMMIT);

  assign empty      = (cnt_q == '0);
  assign full       = (cnt_q == CW'(DEPTH));
  assign young_slot = slot_at(rd_q, cnt_q - CW'(1));
  assign wr_slot    = full ? rd_q : slot_at(rd_q, cnt_q);
  assign head_slot  = slot_at(rd_q, CW'(head_q));

  assign tgt_fire  = do_tgt && !empty;
  assign push_drop = do_push && full;

  assign commit_ok     = do_commit && !empty && (CW'(head_q) < cnt_q)
                         && (seq_arr[head_slot] <= cm_seq);
  assign commit_retire = commit_ok && (head_q >= HW'(PATH_LEN));
  assign commit_adv    = commit_ok && !commit_retire;

  assign squash_cut = do_squash && sq_hit;

  phb_ring #(.DEPTH(DEPTH), .AW(AW), .SW(SW)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (do_push),
    .wr_slot (wr_slot),
    .wr_pc   (ps_pc),
    .wr_seq  (ps_seq),
    .tg_en   (tgt_fire),
    .tg_slot (young_slot),
    .tg_addr (tg_addr),
    .pc_o    (pc_arr),
    .tgt_o   (tgt_arr),
    .seq_o   (seq_arr)
  );

  phb_search #(.DEPTH(DEPTH), .SW(SW)) u_search (
    .rd_ptr (rd_q),
    .cnt    (cnt_q),
    .key    (sq_seq),
    .seq_i  (seq_arr),
    .hit    (sq_hit),
    .off    (sq_off)
  );

  phb_path_sel #(.DEPTH(DEPTH), .PATH_LEN(PATH_LEN), .AW(AW)) u_path (
    .rd_ptr (rd_q),
    .cnt    (cnt_q),
    .tgt_i  (tgt_arr),
    .path_o (path_tgt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      cnt_q  <= '0;
      head_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (squash_cut) begin
        cnt_q <= sq_off;
      end else if (push_drop) begin
        rd_q  <= rd_q + PW'(1);
        ovf_q <= 1'b1;
        if (head_q != '0) head_q <= head_q - HW'(1);
      end else if (do_push) begin
        cnt_q <= cnt_q + CW'(1);
      end else if (commit_retire) begin
        rd_q  <= rd_q + PW'(1);
        cnt_q <= cnt_q - CW'(1);
      end else if (commit_adv) begin
        head_q <= head_q + HW'(1);
      end
    end
  end

  assign occ       = cnt_q;
  assign committed = head_q;
  assign overflow  = ovf_q;
  assign young_pc  = empty ? '0 : pc_arr[young_slot];

endmodule

// File: rtl/path_hist_buf_chk.sv
module path_hist_buf_chk #(
  parameter int DEPTH    = 8,
  parameter int PATH_LEN = 3,
  parameter int AW       = 16,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int HW      = $clog2(PATH_LEN + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sq_en,
  input logic                   tg_en,
  input logic                   ps_en,
  input logic                   cm_en,
  input logic [CW-1:0]          occ,
  input logic [HW-1:0]          committed,
  input logic                   overflow,
  input logic [AW-1:0]          young_pc,
  input logic [PATH_LEN*AW-1:0] path_tgt,
  input logic                   do_squash,
  input logic                   do_tgt,
  input logic                   do_push,
  input logic                   do_commit,
  input logic                   push_drop,
  input logic                   commit_retire,
  input logic                   commit_adv
);

  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && !push_drop) |=> occ == $past(occ) + CW'(1));

  assert_full_push_keeps_occ_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> (occ == CW'(DEPTH)) && overflow);

  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_commit_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_en && !sq_en && !tg_en && !ps_en && occ == '0)
      |=> (occ == '0) && $stable(committed));

  assert_commit_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_retire |=> (occ == $past(occ) - CW'(1)) && $stable(committed));

  assert_commit_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_adv |=> (committed == $past(committed) + HW'(1)) && $stable(occ));

  assert_head_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    committed <= HW'(PATH_LEN));

  assert_squash_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sq_en |=> (occ <= $past(occ)) && $stable(committed));

  assert_empty_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> (path_tgt == '0) && (young_pc == '0));

  assert_one_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({do_squash, do_tgt, do_push, do_commit}));

  assert_squash_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sq_en |-> do_squash);

endmodule

bind path_hist_buf path_hist_buf_chk #(
  .DEPTH(DEPTH), .PATH_LEN(PATH_LEN), .AW(AW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sq_en         (sq_en),
  .tg_en         (tg_en),
  .ps_en         (ps_en),
  .cm_en         (cm_en),
  .occ           (occ),
  .committed     (committed),
  .overflow      (overflow),
  .young_pc      (young_pc),
  .path_tgt      (path_tgt),
  .do_squash     (do_squash),
  .do_tgt        (do_tgt),
  .do_push       (do_push),
  .do_commit     (do_commit),
  .push_drop     (push_drop),
  .commit_retire (commit_retire),
  .commit_adv    (commit_adv)
);

// File: tb/sim_path_hist_buf.sv
`timescale 1ns/1ps
module sim_path_hist_buf;

  localparam int DEPTH = 8;
  localparam int PL    = 3;
  localparam int AW    = 16;
  localparam int SW    = 8;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int HW    = $clog2(PL + 1);

  localparam logic [2:0] K_PUSH = 3'd1, K_TGT = 3'd2, K_CMT = 3'd3, K_SQ = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] a;
    logic [7:0]  s;
    logic [3:0]  req;
    logic [3:0]  occ;
    logic [1:0]  com;
    logic [15:0] p0;
    logic [15:0] p1;
    logic [15:0] p2;
    logic [15:0] yp;
  } vec_t;

  // lane 0 = youngest target; R2 R4 R6 R7 R8 R5 R9 walked in order
  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{K_PUSH, 16'h0100, 8'd1, 4'd2, 4'd1, 2'd0, 16'h0,  16'h0,  16'h0,  16'h0100},
    '{K_TGT,  16'h00A1, 8'd0, 4'd4, 4'd1, 2'd0, 16'hA1, 16'h0,  16'h0,  16'h0100},
    '{K_PUSH, 16'h0200, 8'd2, 4'd2, 4'd2, 2'd0, 16'h0,  16'hA1, 16'h0,  16'h0200},
    '{K_TGT,  16'h00A2, 8'd0, 4'd4, 4'd2, 2'd0, 16'hA2, 16'hA1, 16'h0,  16'h0200},
    '{K_PUSH, 16'h0300, 8'd3, 4'd2, 4'd3, 2'd0, 16'h0,  16'hA2, 16'hA1, 16'h0300},
    '{K_TGT,  16'h00A3, 8'd0, 4'd4, 4'd3, 2'd0, 16'hA3, 16'hA2, 16'hA1, 16'h0300},
    '{K_CMT,  16'h0,    8'd0, 4'd7, 4'd3, 2'd0, 16'hA3, 16'hA2, 16'hA1, 16'h0300},
    '{K_CMT,  16'h0,    8'd5, 4'd6, 4'd3, 2'd1, 16'hA3, 16'hA2, 16'hA1, 16'h0300},
    '{K_CMT,  16'h0,    8'd5, 4'd6, 4'd3, 2'd2, 16'hA3, 16'hA2, 16'hA1, 16'h0300},
    '{K_CMT,  16'h0,    8'd5, 4'd6, 4'd3, 2'd3, 16'hA3, 16'hA2, 16'hA1, 16'h0300},
    '{K_CMT,  16'h0,    8'd5, 4'd6, 4'd3, 2'd3, 16'hA3, 16'hA2, 16'hA1, 16'h0300},
    '{K_PUSH, 16'h0400, 8'd4, 4'd2, 4'd4, 2'd3, 16'h0,  16'hA3, 16'hA2, 16'h0400},
    '{K_TGT,  16'h00A4, 8'd0, 4'd4, 4'd4, 2'd3, 16'hA4, 16'hA3, 16'hA2, 16'h0400},
    '{K_CMT,  16'h0,    8'd4, 4'd6, 4'd3, 2'd3, 16'hA4, 16'hA3, 16'hA2, 16'h0400},
    '{K_PUSH, 16'h0500, 8'd6, 4'd2, 4'd4, 2'd3, 16'h0,  16'hA4, 16'hA3, 16'h0500},
    '{K_SQ,   16'h0,    8'd5, 4'd8, 4'd3, 2'd3, 16'hA4, 16'hA3, 16'hA2, 16'h0400},
    '{K_SQ,   16'h0,    8'd1, 4'd8, 4'd0, 2'd3, 16'h0,  16'h0,  16'h0,  16'h0},
    '{K_CMT,  16'h0,    8'd9, 4'd5, 4'd0, 2'd3, 16'h0,  16'h0,  16'h0,  16'h0},
    '{K_TGT,  16'h00AF, 8'd0, 4'd4, 4'd0, 2'd3, 16'h0,  16'h0,  16'h0,  16'h0},
    '{K_PUSH, 16'h0600, 8'd7, 4'd9, 4'd1, 2'd3, 16'h0,  16'h0,  16'h0,  16'h0600},
    '{K_CMT,  16'h0,    8'd9, 4'd6, 4'd1, 2'd3, 16'h0,  16'h0,  16'h0,  16'h0600}
  };

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 sq_en = 1'b0, tg_en = 1'b0, ps_en = 1'b0, cm_en = 1'b0;
  logic [SW-1:0]        sq_seq = '0, ps_seq = '0, cm_seq = '0;
  logic [AW-1:0]        tg_addr = '0, ps_pc = '0;
  logic [CW-1:0]        occ;
  logic [HW-1:0]        committed;
  logic                 overflow;
  logic [AW-1:0]        young_pc;
  logic [PL*AW-1:0]     path_tgt;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  path_hist_buf #(.DEPTH(DEPTH), .PATH_LEN(PL), .AW(AW), .SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .sq_en(sq_en), .sq_seq(sq_seq),
    .tg_en(tg_en), .tg_addr(tg_addr),
    .ps_en(ps_en), .ps_pc(ps_pc), .ps_seq(ps_seq),
    .cm_en(cm_en), .cm_seq(cm_seq),
    .occ(occ), .committed(committed), .overflow(overflow),
    .young_pc(young_pc), .path_tgt(path_tgt)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive requests for one clock, sample at the following falling edge
  task automatic drive(input logic sq, input logic tg, input logic ps, input logic cm,
                       input logic [AW-1:0] a, input logic [SW-1:0] s);
    @(negedge clk);
    sq_en = sq; tg_en = tg; ps_en = ps; cm_en = cm;
    tg_addr = a; ps_pc = a; sq_seq = s; ps_seq = s; cm_seq = s;
    @(negedge clk);
    sq_en = 1'b0; tg_en = 1'b0; ps_en = 1'b0; cm_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic chk_lanes(input string req, input logic [15:0] e0,
                           input logic [15:0] e1, input logic [15:0] e2);
    chk(req, "lane0", 32'(path_tgt[15:0]),  32'(e0));
    chk(req, "lane1", 32'(path_tgt[31:16]), 32'(e1));
    chk(req, "lane2", 32'(path_tgt[47:32]), 32'(e2));
  endtask

  initial begin
    do_reset();
    // R1: reset state
    chk("R1", "occ", 32'(occ), 0);
    chk("R1", "committed", 32'(committed), 0);
    chk("R1", "overflow", 32'(overflow), 0);
    chk("R1", "young_pc", 32'(young_pc), 0);
    chk_lanes("R1", 16'h0, 16'h0, 16'h0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i].req);
      drive(VEC[i].op == K_SQ, VEC[i].op == K_TGT, VEC[i].op == K_PUSH,
            VEC[i].op == K_CMT, VEC[i].a, VEC[i].s);
      chk(rq, $sformatf("vec%0d occ", i), 32'(occ), 32'(VEC[i].occ));
      chk(rq, $sformatf("vec%0d committed", i), 32'(committed), 32'(VEC[i].com));
      chk(rq, $sformatf("vec%0d young_pc", i), 32'(young_pc), 32'(VEC[i].yp));
      chk_lanes(rq, VEC[i].p0, VEC[i].p1, VEC[i].p2);
    end

    // R3: fill past capacity, oldest record must be dropped
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      drive(1'b0, 1'b0, 1'b1, 1'b0, AW'(16 * (i + 1)), SW'(i + 1));
      drive(1'b0, 1'b1, 1'b0, 1'b0, AW'(16'hB0 + i), '0);
    end
    chk("R3", "full occ", 32'(occ), DEPTH);
    chk("R3", "no overflow yet", 32'(overflow), 0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 16'h0900, 8'd9);
    chk("R3", "occ after drop", 32'(occ), DEPTH);
    chk("R3", "overflow set", 32'(overflow), 1);
    chk("R3", "young_pc", 32'(young_pc), 32'h900);
    chk_lanes("R3", 16'h0, 16'hB7, 16'hB6);
    // oldest left should be seq 2: squash at 2 keeps exactly one record
    drive(1'b1, 1'b0, 1'b0, 1'b0, '0, 8'd2);
    chk("R3", "oldest was dropped", 32'(occ), 1);
    chk("R3", "surviving pc", 32'(young_pc), 32'h20);
    chk_lanes("R8", 16'hB1, 16'h0, 16'h0);
    chk("R3", "overflow sticky", 32'(overflow), 1);

    // R1: reset clears a populated buffer
    do_reset();
    chk("R1", "occ after reset", 32'(occ), 0);
    chk("R1", "overflow after reset", 32'(overflow), 0);

    // R10: simultaneous requests
    drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h0100, 8'd1);
    chk("R10", "push beats commit occ", 32'(occ), 1);
    chk("R10", "push beats commit head", 32'(committed), 0);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 16'h00C1, 8'd2);
    chk("R10", "target beats push occ", 32'(occ), 1);
    chk("R10", "target beats push lane0", 32'(path_tgt[15:0]), 32'hC1);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 16'h0333, 8'd0);
    chk("R10", "squash beats all occ", 32'(occ), 0);
    chk("R10", "squash beats all head", 32'(committed), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule